// File: doc/BRIEF.md
# Stream Engine Status Byte

This block holds the 8-bit status byte of one audio DMA stream engine, along with the event logic behind it. The parameter `IS_INPUT` builds it for either a capture (input) stream or a playback (output) stream. It watches the stream FIFO fill level, pulses that report a failed descriptor fetch, end-of-buffer events and their interrupt-on-completion flag, and the stream's RUN bit, which it owns.

The byte reports a live readiness flag and three sticky event flags. Software clears each sticky flag by writing a 1 to its bit position. A failed descriptor fetch stops the stream by clearing RUN. In an input build, incoming words that arrive while the FIFO is full are refused: the FIFO write strobe stays low, so the write pointer does not advance. In an output build, the link transmit strobe is held low whenever the FIFO is empty. Each sticky flag has an enable, and the enabled flags are ORed onto one interrupt line.

Top module: `stream_status_reg`

## Requirements
- R1: The read byte `reg_rdata` reflects the current state with no wait cycle. Bit 5 is FIFO ready, bit 4 is descriptor error, bit 3 is FIFO error and bit 2 is buffer-complete. Bits 7:6 and 1:0 always read as 0.
- R2: After reset, the status byte, `run`, `irq`, `fifo_wr` and `link_tx` are all 0.
- R3: A write with bit 4, 3 or 2 of `reg_wdata` at 1 clears the matching sticky flag at the next clock edge. A 0 in that position leaves the flag unchanged. Writes to bit 5 and to the reserved bits have no effect.
- R4: If a hardware set and a software clear reach the same sticky flag in the same cycle, the flag ends up at 1.
- R5: A `desc_err` pulse sets bit 4 and forces `run` to 0 at the next edge, even if `run_set` is high in the same cycle. A later `run_set` starts the stream again.
- R6: Output build: bit 5 becomes 1 one cycle after `fifo_level >= READY_LEVEL`, and becomes 0 one cycle after the level falls below it.
- R7: Input build: bit 5 follows `desc_loaded` with one cycle of delay.
- R8: Input build: `fifo_wr = run & in_push & (fifo_level < DEPTH)`. When `run`, `in_push` and a full FIFO (`fifo_level == DEPTH`) occur together, bit 3 is set at the next edge.
- R9: Output build: `link_tx = run & out_pull & (fifo_level != 0)`. When `run` and `out_pull` are high, the level is 0 and `bufs_left` is high, bit 3 is set at the next edge. With `bufs_left` low, bit 3 is not set.
- R10: While `run` is 0, bit 3 is never set, and both `fifo_wr` and `link_tx` stay 0.
- R11: Bit 2 is set one cycle after a `buf_done` pulse that carries `buf_ioc = 1`. A `buf_done` without `buf_ioc` leaves bit 2 unchanged.
- R12: `irq = (bit4 & ie_desc) | (bit3 & ie_fifo) | (bit2 & ie_buf)`, with no delay. The enables do not affect whether a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | 8 | Write data; a 1 clears the matching sticky flag |
| reg_rdata | output | 8 | Status byte |
| run_set | input | 1 | Software request to set RUN |
| run_clr | input | 1 | Software request to clear RUN |
| run | output | 1 | Stream RUN bit |
| fifo_level | input | $clog2(DEPTH+1) | Current FIFO fill in words |
| desc_loaded | input | 1 | Input build: a valid descriptor is loaded |
| desc_err | input | 1 | Descriptor fetch failed (pulse) |
| buf_done | input | 1 | Last sample of a buffer processed (pulse) |
| buf_ioc | input | 1 | Interrupt-on-completion flag of that buffer |
| bufs_left | input | 1 | Output build: buffers still queued |
| in_push | input | 1 | Input build: incoming word from the link |
| fifo_wr | output | 1 | Input build: gated FIFO write strobe |
| out_pull | input | 1 | Output build: link slot requests a word |
| link_tx | output | 1 | Output build: gated transmit strobe |
| ie_desc | input | 1 | Interrupt enable for descriptor error |
| ie_fifo | input | 1 | Interrupt enable for FIFO error |
| ie_buf | input | 1 | Interrupt enable for buffer-complete |
| irq | output | 1 | Combined stream interrupt |

## Verification
The assertions check these properties on every cycle:
- the reserved bits read as 0;
- a sticky flag stays set unless a clearing write arrives;
- a descriptor error stops RUN;
- FIFO writes are refused when the FIFO is full;
- nothing is transmitted from an empty FIFO;
- no FIFO error is raised while the stream is idle.

Other behaviours need the bench's scenarios:
- the readiness threshold, which the bench sweeps over every fill level;
- the write-one-to-clear rule, which the bench tests for all 256 write values;
- set-over-clear priority in the same cycle;
- the gating of completion by the interrupt-on-completion flag;
- the difference between an underrun with buffers queued and one without;
- the interrupt enable combinations.

// File: rtl/stream_status_reg.sv
module stream_status_reg #(
  parameter bit IS_INPUT    = 1'b0,
  parameter int DEPTH       = 8,
  parameter int READY_LEVEL = 4,
  localparam int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          run_set,
  input  logic          run_clr,
  output logic          run,
  input  logic [LW-1:0] fifo_level,
  input  logic          desc_loaded,
  input  logic          desc_err,
  input  logic          buf_done,
  input  logic          buf_ioc,
  input  logic          bufs_left,
  input  logic          in_push,
  output logic          fifo_wr,
  input  logic          out_pull,
  output logic          link_tx,
  input  logic          ie_desc,
  input  logic          ie_fifo,
  input  logic          ie_buf,
  output logic          irq
);

  logic rdy_q, derr_q, ferr_q, bdone_q;
  logic rdy_d, ferr_set;

  wire fifo_empty = (fifo_level == '0);
  wire fifo_full  = (fifo_level >= LW'(DEPTH));
  wire clr_derr   = reg_wr & reg_wdata[4];
  wire clr_ferr   = reg_wr & reg_wdata[3];
  wire clr_bdone  = reg_wr & reg_wdata[2];

  generate
    if (IS_INPUT) begin : g_in
      assign rdy_d    = desc_loaded;
      assign ferr_set = run & in_push & fifo_full;
      assign fifo_wr  = run & in_push & ~fifo_full;
      assign link_tx  = 1'b0;
      wire unused_in = &{1'b0, out_pull, bufs_left, fifo_empty};
    end else begin : g_out
      assign rdy_d    = (fifo_level >= LW'(READY_LEVEL));
      assign ferr_set = run & out_pull & fifo_empty & bufs_left;
      assign link_tx  = run & out_pull & ~fifo_empty;
      assign fifo_wr  = 1'b0;
      wire unused_out = &{1'b0, in_push, desc_loaded, fifo_full};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      rdy_q   <= 1'b0;
      derr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      bdone_q <= 1'b0;
    end else begin
      if (desc_err)     run <= 1'b0;
      else if (run_clr) run <= 1'b0;
      else if (run_set) run <= 1'b1;
      rdy_q   <= rdy_d;
      derr_q  <= (derr_q  & ~clr_derr)  | desc_err;
      ferr_q  <= (ferr_q  & ~clr_ferr)  | ferr_set;
      bdone_q <= (bdone_q & ~clr_bdone) | (buf_done & buf_ioc);
    end
  end

  assign reg_rdata = {2'b00, rdy_q, derr_q, ferr_q, bdone_q, 2'b00};
  assign irq = (derr_q & ie_desc) | (ferr_q & ie_fifo) | (bdone_q & ie_buf);

endmodule

// File: rtl/stream_status_chk.sv
module stream_status_chk #(
  parameter bit IS_INPUT = 1'b0,
  parameter int DEPTH    = 8,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          run,
  input logic [LW-1:0] fifo_level,
  input logic          desc_err,
  input logic          in_push,
  input logic          out_pull,
  input logic          fifo_wr,
  input logic          link_tx
);

  always_comb begin
    if (rst_n) a_r1_reserved_zero: assert (reg_rdata[7:6] == 2'b00 && reg_rdata[1:0] == 2'b00);
  end

  a_r5_desc_err_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |=> (!run && reg_rdata[4]));

  a_r3_derr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4] && !(reg_wr && reg_wdata[4])) |=> reg_rdata[4]);

  a_r3_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3] && !(reg_wr && reg_wdata[3])) |=> reg_rdata[3]);

  a_r3_bdone_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !(reg_wr && reg_wdata[2])) |=> reg_rdata[2]);

  a_r10_idle_no_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_rdata[3]) |=> !reg_rdata[3]);

  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!fifo_wr && !link_tx));

  generate
    if (IS_INPUT) begin : g_in
      a_r8_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level >= LW'(DEPTH)) |-> !fifo_wr);
      a_r8_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (run && in_push && fifo_level >= LW'(DEPTH)) |=> reg_rdata[3]);
    end else begin : g_out
      a_r9_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !link_tx);
      a_r9_pull_sends: assert property (@(posedge clk) disable iff (!rst_n)
        (run && out_pull && fifo_level != '0) |-> link_tx);
    end
  endgenerate

endmodule

bind stream_status_reg stream_status_chk #(.IS_INPUT(IS_INPUT), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .run(run), .fifo_level(fifo_level),
  .desc_err(desc_err), .in_push(in_push), .out_pull(out_pull),
  .fifo_wr(fifo_wr), .link_tx(link_tx)
);

// File: tb/stream_status_reg_test.sv
module stream_status_reg_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int RDY    = 4;
  localparam int LW     = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, run_set = 0, run_clr = 0, desc_loaded = 0, desc_err = 0;
  logic buf_done = 0, buf_ioc = 0, bufs_left = 0, in_push = 0, out_pull = 0;
  logic ie_desc = 0, ie_fifo = 0, ie_buf = 0;
  logic [7:0] reg_wdata = 0;
  logic [LW-1:0] fifo_level = 0;
  logic [7:0] o_rd, i_rd;
  logic o_run, i_run, o_wr, i_wr, o_tx, i_tx, o_irq, i_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  stream_status_reg #(.IS_INPUT(1'b0), .DEPTH(DEPTH), .READY_LEVEL(RDY)) uut (
    .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata(o_rd), .run_set, .run_clr, .run(o_run),
    .fifo_level, .desc_loaded, .desc_err, .buf_done, .buf_ioc, .bufs_left,
    .in_push, .fifo_wr(o_wr), .out_pull, .link_tx(o_tx), .ie_desc, .ie_fifo, .ie_buf, .irq(o_irq));

  stream_status_reg #(.IS_INPUT(1'b1), .DEPTH(DEPTH), .READY_LEVEL(RDY)) uut_in (
    .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata(i_rd), .run_set, .run_clr, .run(i_run),
    .fifo_level, .desc_loaded, .desc_err, .buf_done, .buf_ioc, .bufs_left,
    .in_push, .fifo_wr(i_wr), .out_pull, .link_tx(i_tx), .ie_desc, .ie_fifo, .ie_buf, .irq(i_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic quiet;
    reg_wr = 0; reg_wdata = 0; run_set = 0; run_clr = 0; desc_err = 0;
    buf_done = 0; buf_ioc = 0; in_push = 0; out_pull = 0;
  endtask

  task automatic clear_all;
    quiet; reg_wr = 1; reg_wdata = 8'hFF; tick; quiet;
  endtask

  initial begin
    repeat (3) tick;
    chk("R2 out byte", o_rd, 0);  chk("R2 in byte", i_rd, 0);
    chk("R2 run", {o_run, i_run}, 0); chk("R2 irq", {o_irq, i_irq}, 0);
    chk("R2 strobes", {o_wr, o_tx, i_wr, i_tx}, 0);
    rst_n = 1; tick;

    for (int lv = 0; lv <= DEPTH; lv++) begin
      fifo_level = LW'(lv); tick;
      chk("R6 ready threshold", o_rd[5], (lv >= RDY));
      chk("R7 no descriptor", i_rd[5], 0);
    end
    for (int lv = DEPTH; lv >= 0; lv--) begin
      fifo_level = LW'(lv); tick;
      chk("R6 ready falling", o_rd[5], (lv >= RDY));
    end

    desc_loaded = 1; tick; chk("R7 ready on descriptor", i_rd[5], 1);
    desc_loaded = 0; tick; chk("R7 ready drops", i_rd[5], 0);

    run_set = 1; tick; quiet; chk("R5 run starts", o_run, 1);
    desc_err = 1; tick; quiet;
    chk("R5 run stopped", o_run, 0); chk("R5 derr set", o_rd[4], 1);
    chk("R12 irq masked", o_irq, 0);
    ie_desc = 1; #1; chk("R12 irq enabled", o_irq, 1); ie_desc = 0;
    run_set = 1; desc_err = 1; tick; quiet;
    chk("R5 error beats run_set", o_run, 0);
    run_set = 1; tick; quiet; chk("R5 restart", o_run, 1);
    clear_all; chk("R3 clear all", o_rd, 0);

    for (int w = 0; w < 256; w++) begin
      fifo_level = 0; bufs_left = 1;
      run_set = 1; tick; quiet;
      desc_err = 1; buf_done = 1; buf_ioc = 1; out_pull = 1; tick; quiet;
      reg_wr = 1; reg_wdata = 8'(w); tick; quiet;
      chk("R3 out w1c", o_rd, {3'b000, 3'b111 & ~w[4:2], 2'b00});
      chk("R3 in w1c", i_rd, {3'b000, 3'b101 & ~w[4:2], 2'b00});
      clear_all;
    end
    bufs_left = 0;

    buf_done = 1; buf_ioc = 1; reg_wr = 1; reg_wdata = 8'h04; tick; quiet;
    chk("R4 set beats clear", o_rd[2], 1);
    clear_all;
    buf_done = 1; buf_ioc = 0; tick; quiet;
    chk("R11 no ioc no flag", o_rd[2], 0);
    buf_done = 1; buf_ioc = 1; tick; quiet;
    chk("R11 ioc sets flag", o_rd[2], 1);
    clear_all;

    run_set = 1; tick; quiet;
    fifo_level = LW'(DEPTH); in_push = 1; #1;
    chk("R8 full refused", i_wr, 0);
    tick; in_push = 0;
    chk("R8 overrun flag", i_rd[3], 1);
    fifo_level = 3; in_push = 1; #1;
    chk("R8 space accepted", i_wr, 1);
    chk("R8 output build never writes", o_wr, 0);
    in_push = 0; clear_all;

    fifo_level = 0; out_pull = 1; bufs_left = 0; #1;
    chk("R9 empty no tx", o_tx, 0);
    tick; chk("R9 no buffers no error", o_rd[3], 0);
    bufs_left = 1; tick; chk("R9 underrun flag", o_rd[3], 1);
    fifo_level = 5; #1; chk("R9 data sent", o_tx, 1);
    chk("R9 input build never sends", i_tx, 0);
    quiet; bufs_left = 0; clear_all;

    run_clr = 1; tick; quiet;
    chk("R10 run cleared", {o_run, i_run}, 0);
    fifo_level = 0; out_pull = 1; bufs_left = 1; tick;
    chk("R10 idle no underrun", o_rd[3], 0); chk("R10 idle no tx", o_tx, 0);
    out_pull = 0; fifo_level = LW'(DEPTH); in_push = 1; tick;
    chk("R10 idle no overrun", i_rd[3], 0); chk("R10 idle no write", i_wr, 0);
    quiet; bufs_left = 0;

    run_set = 1; tick; quiet;
    fifo_level = 0; out_pull = 1; bufs_left = 1; desc_err = 1; buf_done = 1; buf_ioc = 1;
    tick; quiet; bufs_left = 0;
    chk("R12 all flags set", o_rd[4:2], 3'b111);
    for (int e = 0; e < 8; e++) begin
      {ie_desc, ie_fifo, ie_buf} = 3'(e); #1;
      chk("R12 irq combine", o_irq, (e != 0));
    end
    ie_desc = 0; ie_fifo = 0; ie_buf = 0;
    reg_wr = 1; reg_wdata = 8'h08; tick; quiet;
    chk("R3 single clear", o_rd[4:2], 3'b101);
    ie_fifo = 1; #1; chk("R12 cleared flag masked", o_irq, 0);
    chk("R1 layout", o_rd & 8'hC3, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule